// File: doc/BRIEF.md
# Gain-Ranging Input Exponent Scaler

This block sits between a gain-ranging (floating-point style) analog-to-digital converter and the first decimating filter. Each input sample is a 14-bit two's-complement mantissa paired with a 3-bit unsigned exponent. The block works out a right-shift amount from the exponent and applies it to the mantissa. The shift amount comes from the exponent, optionally inverted, plus a programmable offset, with the sum wrapped modulo 8. The result is a sign-preserving fixed-point word that carries seven extra fractional bits, so no shift loses precision.

Converters use different exponent conventions. Some raise the exponent as the signal gets louder and some lower it. Others cover only part of the eight possible steps. The invert control and the offset let any of these map onto a zero-shift full-scale point. A converter with no exponent ties the exponent to zero and programs both controls to zero, which gives a straight pass-through.

Alongside each sample, the block also chooses one of two 5-bit scale values from a single control word. A level flag picks which one: it marks whether the input is loud or quiet. The chosen scale is captured together with the sample so that the downstream stage receives a matched pair.

Top module: `gr_exp_scaler`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `out_scale` are all zero.
- R2: The block captures a sample at a rising clock edge where `in_valid` is high. From that edge on, `out_valid` is high and `out_data` and `out_scale` hold the result for that sample. The latency is one cycle.
- R3: With `exp_invert` = 0, the right-shift amount is (exponent + `exp_offset`) mod 8. For example, exponent 5 with offset 0 gives a shift of 5.
- R4: With `exp_invert` = 1, the right-shift amount is (7 − exponent + `exp_offset`) mod 8. Offset 0 maps exponent 5 to shift 2 and exponent 0 to shift 7. Offset 6 maps exponent 5 to shift 0 and exponent 0 to shift 5.
- R5: `out_data` is 21 bits wide, two's complement, with the binary point 7 bits from the LSB. Its value equals the mantissa times 2^7, arithmetically shifted right by the shift amount. The result is exact and keeps the mantissa's sign.
- R6: `scale_word[4:0]` holds the loud scale and `scale_word[9:5]` holds the quiet scale. `out_scale` takes the loud value when `level_loud` is 1 at the capture edge and the quiet value when it is 0.
- R7: With the exponent at 0, `exp_invert` = 0 and `exp_offset` = 0, `out_data` equals the mantissa followed by seven zero bits. No scaling is applied.
- R8: A rising edge with `in_valid` low drives `out_valid` low and leaves `out_data` and `out_scale` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present |
| mant | input | 14 | Two's-complement mantissa |
| expo | input | 3 | Unsigned exponent |
| exp_invert | input | 1 | Invert the exponent sense before adding the offset |
| exp_offset | input | 3 | Offset added to the (possibly inverted) exponent, mod 8 |
| scale_word | input | 10 | Loud scale in bits 4..0, quiet scale in bits 9..5 |
| level_loud | input | 1 | Level flag: 1 selects the loud scale |
| out_valid | output | 1 | Output sample is present |
| out_data | output | 21 | Shifted sample with 7 fractional bits |
| out_scale | output | 5 | Scale captured with the sample |

## Verification
Within a single capture edge, a change of level flag and a change of exponent can both reach the output. The flag switches the scale selection while the new exponent changes the shift. The bench makes both change on the same sample, in directed steps and throughout the random run, where level, exponent, invert and offset are all drawn fresh for every sample. It then checks that `out_scale` and `out_data` both belong to that same sample, so that neither one lags a cycle behind the other.

// File: rtl/gr_exp_scaler.sv
module gr_exp_scaler #(
  parameter int MANT_W  = 14,
  parameter int EXP_W   = 3,
  parameter int SCALE_W = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic [MANT_W-1:0]                      mant,
  input  logic [EXP_W-1:0]                       expo,
  input  logic                                   exp_invert,
  input  logic [EXP_W-1:0]                       exp_offset,
  input  logic [2*SCALE_W-1:0]                   scale_word,
  input  logic                                   level_loud,
  output logic                                   out_valid,
  output logic [MANT_W+(1<<EXP_W)-2:0]           out_data,
  output logic [SCALE_W-1:0]                     out_scale
);
  localparam int FRAC_W = (1 << EXP_W) - 1;
  localparam int OUT_W  = MANT_W + FRAC_W;

  logic [EXP_W-1:0]        exp_eff;
  logic [EXP_W-1:0]        shift_amt;
  logic signed [OUT_W-1:0] aligned;
  logic signed [OUT_W-1:0] shifted;
  logic [SCALE_W-1:0]      scale_sel;

  assign exp_eff   = exp_invert ? ~expo : expo;
  assign shift_amt = exp_eff + exp_offset;
  assign aligned   = $signed({mant, {FRAC_W{1'b0}}});
  assign shifted   = aligned >>> shift_amt;
  assign scale_sel = level_loud ? scale_word[SCALE_W-1:0]
                                : scale_word[2*SCALE_W-1:SCALE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_scale <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= shifted;
        out_scale <= scale_sel;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0 && out_scale == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[OUT_W-1] == $past(mant[MANT_W-1])); // R5

  AST_LOUD_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && level_loud) |=> out_scale == $past(scale_word[SCALE_W-1:0])); // R6

  AST_QUIET_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !level_loud) |=> out_scale == $past(scale_word[2*SCALE_W-1:SCALE_W])); // R6

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !exp_invert && exp_offset == '0 && expo == '0)
      |=> out_data == {$past(mant), {FRAC_W{1'b0}}}); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_scale))); // R8
endmodule

// File: tb/test_gr_exp_scaler.sv
module test_gr_exp_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] mant = '0;
  logic [2:0]  expo = '0;
  logic        exp_invert = 1'b0;
  logic [2:0]  exp_offset = '0;
  logic [9:0]  scale_word = '0;
  logic        level_loud = 1'b0;
  logic        out_valid;
  logic [20:0] out_data;
  logic [4:0]  out_scale;

  int checks = 0;
  int fails  = 0;

  gr_exp_scaler i_gr_exp_scaler (
    .clk, .rst_n, .in_valid, .mant, .expo, .exp_invert, .exp_offset,
    .scale_word, .level_loud, .out_valid, .out_data, .out_scale
  );

  always #5 clk = ~clk;

  function automatic int want_shift(int e, bit inv, int off);
    if (inv) return (7 - e + off + 16) % 8;
    return (e + off) % 8;
  endfunction

  function automatic logic [20:0] want_data(logic [13:0] m, int sh);
    longint v;
    longint d;
    v = longint'($signed(m)) * 128;
    d = longint'(1) << sh;
    if (v >= 0) v = v / d;
    else v = -((-v + d - 1) / d);
    return v[20:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [13:0] m, logic [2:0] e, bit inv, logic [2:0] off,
                       logic [9:0] sw, bit loud, string req);
    logic [20:0] ed;
    logic [4:0]  es;
    mant = m; expo = e; exp_invert = inv; exp_offset = off;
    scale_word = sw; level_loud = loud; in_valid = 1'b1;
    ed = want_data(m, want_shift(int'(e), inv, int'(off)));
    es = loud ? sw[4:0] : sw[9:5];
    @(negedge clk);
    check(out_valid == 1'b1, {req, "/R2 valid"}, out_valid, 1);
    check(out_data == ed, {req, " data"}, out_data, ed);
    check(out_scale == es, {req, "/R6 scale"}, out_scale, es);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [20:0] held_d;
    logic [4:0]  held_s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_data == 0 && out_scale == 0, "R1 reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(14'h0123, 3'd0, 1'b0, 3'd0, 10'h000, 1'b1, "R7 pass-through");
    apply(14'h3ABC, 3'd0, 1'b0, 3'd0, 10'h000, 1'b0, "R7 negative pass-through");
    apply(14'h1F40, 3'd5, 1'b0, 3'd0, {5'd3, 5'd17}, 1'b1, "R3 exp5 shift5");
    apply(14'h2001, 3'd5, 1'b1, 3'd0, {5'd3, 5'd17}, 1'b0, "R4 exp5 off0 shift2");
    apply(14'h2001, 3'd0, 1'b1, 3'd0, {5'd9, 5'd30}, 1'b1, "R4 exp0 off0 shift7");
    apply(14'h1555, 3'd5, 1'b1, 3'd6, {5'd9, 5'd30}, 1'b0, "R4 exp5 off6 shift0");
    apply(14'h3FFF, 3'd0, 1'b1, 3'd6, {5'd1, 5'd2}, 1'b1, "R4 exp0 off6 shift5");
    apply(14'h3FFF, 3'd7, 1'b0, 3'd0, {5'd1, 5'd2}, 1'b0, "R5 minus-one shift7");
    apply(14'h2000, 3'd7, 1'b0, 3'd0, {5'd31, 5'd0}, 1'b1, "R5 most-negative shift7");
    apply(14'h1FFF, 3'd6, 1'b0, 3'd3, {5'd31, 5'd0}, 1'b0, "R3 wrap 6+3");

    held_d = out_data;
    held_s = out_scale;
    in_valid = 1'b0; mant = 14'h0AAA; expo = 3'd2; level_loud = 1'b1;
    scale_word = 10'h3FF;
    @(negedge clk);
    check(out_valid == 0, "R8 valid low", out_valid, 0);
    check(out_data == held_d, "R8 data held", out_data, held_d);
    check(out_scale == held_s, "R8 scale held", out_scale, held_s);
    mant = 14'h1234; level_loud = 1'b0; scale_word = 10'h155;
    @(negedge clk);
    check(out_data == held_d && out_scale == held_s, "R8 held second cycle",
          out_data, held_d);

    for (int i = 0; i < 400; i++) begin
      apply(14'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
            10'($urandom), 1'($urandom), "R5 random");
      if (($urandom % 8) == 0) begin
        held_d = out_data;
        in_valid = 1'b0; mant = 14'($urandom);
        @(negedge clk);
        check(out_valid == 0 && out_data == held_d, "R8 random idle", out_data, held_d);
      end
    end

    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_data == 0 && out_scale == 0, "R1 mid-run reset", out_data, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule